// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

This block is a synchronous static RAM with a 32-bit word and a depth set by a parameter. The rising clock edge registers every address, data and control input. A small burst sequencer generates the word addresses: a load strobe takes a start address, and each later advance strobe steps its two low address bits. The step order is either a linear count or an exclusive-OR (interleaved) pattern.

Writes complete inside the block on the edge that follows the edge that sampled the command, with no external timing. They cover one to four bytes. A global write strobe writes the whole word. Four per-lane strobes write single lanes when a byte-write enable is also low. Reads pass through an input register and then an output register, and their result is gated by an asynchronous output enable onto a data-valid flag. Three chip enables must all be in their enabling states before a command is taken. A sleep input powers the block down. After sleep falls, commands are ignored for a further three clock cycles.

Top module: `pburst_sram`

## Requirements
- R1: With gw_n high and bwe_n low, a low bw_n[i] writes only lane i, which is data bits 8*i+7 to 8*i (lane 0 is bits 7:0, lane 3 is bits 31:24). The other lanes keep their old contents.
- R2: A low gw_n writes all four lanes, whatever the values of bwe_n and bw_n.
- R3: When gw_n is high and either bwe_n is high or all of bw_n are high, the command is a read and changes no stored byte.
- R4: A command with ld high loads the start address. A command with adv high (and ld low) steps the low two address bits. The offset n goes 0,1,2,3. In linear mode (linear=1) the low bits are (start+n) mod 4, and in interleaved mode (linear=0) they are start XOR n. The upper address bits never change within a burst. A command with neither strobe reuses the current address.
- R5: A command is taken only when ce1=1, ce2=1 and ce3_n=0. Any other combination leaves the memory unchanged and produces no valid read data.
- R6: While sleep is high, and for the three clock edges after sleep is first sampled low, commands are ignored and the stored contents are kept. The command at the fourth edge is taken.
- R7: Read data for a command sampled at clock edge k appears on rdata, with rvalid high, just after edge k+1. Back-to-back reads return one word per cycle.
- R8: A read issued in the cycle right after a write to the same address returns the newly written data.
- R9: rvalid is high only while oe is high, and rdata is zero whenever rvalid is low. oe acts without a clock edge.
- R10: After reset, rvalid is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sleep | input | 1 | High: power-down; three-cycle wake-up after it falls |
| ce1 | input | 1 | Chip enable, active high |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld | input | 1 | Load burst start address from addr |
| adv | input | 1 | Advance burst offset |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write strobes, active low |
| wdata | input | 32 | Write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with ADDR_W=6 (64 words), which is enough to place a burst at the very top of the array at 0x3D and show that the wrap stays inside 0x3C..0x3F. It keeps the default three-cycle wake-up, so the bench can step through each ignored edge after sleep and then reach the first accepted one. Bursts are read back to back in both orders, with a hold step in the middle, so one pass covers the pipeline latency, the address order and address reuse.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Low two address bits for burst offset 'step' from start 'start'.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       lin);
    return lin ? (start + step) : (start ^ step);
  endfunction

  // Lanes written by one command; zero means the command is a read.
  function automatic logic [LANES-1:0] lane_mask(input logic             gw_n,
                                                 input logic             bwe_n,
                                                 input logic [LANES-1:0] bw_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~bw_n;
    else             return '0;
  endfunction
endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
  import pbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          ld,
  input  logic          adv,
  input  logic          linear,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (accept && ld) begin
      base_q <= addr;
      step_q <= '0;
    end else if (accept && adv) begin
      step_q <= step_q + 2'd1;
    end
  end

  assign eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], step_q, linear)};
endmodule

// File: rtl/pbs_wake_ctl.sv
module pbs_wake_ctl #(
  parameter int WAKE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic awake
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_q <= '0;
    else if (sleep)          wait_q <= CW'(WAKE_CYCLES);
    else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  assign awake = !sleep && (wait_q == '0);
endmodule

// File: rtl/pbs_core.sv
module pbs_core
  import pbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [LANES-1:0]  mask_in,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     eff_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_ok,
  output logic              wr_fire,
  output logic [LANES-1:0]  wr_mask_q
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              s1_act;
  logic [WORD_W-1:0] s1_data;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] merged;
  logic              s1_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_act    <= 1'b0;
      wr_mask_q <= '0;
      rd_ok     <= 1'b0;
    end else begin
      s1_act    <= accept;
      wr_mask_q <= accept ? mask_in : '0;
      rd_ok     <= s1_read;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) s1_data <= wdata;
  end

  assign cur_word = mem[eff_addr];
  assign s1_read  = s1_act && (wr_mask_q == '0);
  assign wr_fire  = s1_act && (wr_mask_q != '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = wr_mask_q[g] ? s1_data[g*LANE_W +: LANE_W]
                                                     : cur_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[eff_addr] <= merged;
    if (s1_read) rd_word <= cur_word;
  end
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WAKE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce1,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              ld,
  input  logic              adv,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic [31:0]       wdata,
  input  logic              oe,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  logic              selected;
  logic              awake;
  logic              accept;
  logic [LANES-1:0]  cmd_mask;
  logic [ADDR_W-1:0] eff_addr;
  logic [WORD_W-1:0] rd_word;
  logic              rd_ok;
  logic              wr_fire;
  logic [LANES-1:0]  wr_mask_q;

  assign selected = ce1 && ce2 && !ce3_n;
  assign accept   = selected && awake;
  assign cmd_mask = lane_mask(gw_n, bwe_n, bw_n);

  pbs_wake_ctl #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .awake(awake)
  );

  pbs_burst_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ld(ld), .adv(adv),
    .linear(linear), .addr(addr), .eff_addr(eff_addr)
  );

  pbs_core #(.AW(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mask_in(cmd_mask),
    .wdata(wdata), .eff_addr(eff_addr), .rd_word(rd_word), .rd_ok(rd_ok),
    .wr_fire(wr_fire), .wr_mask_q(wr_mask_q)
  );

  assign rvalid = oe && rd_ok;
  assign rdata  = rvalid ? rd_word : '0;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          ce1,
  input logic          ce2,
  input logic          ce3_n,
  input logic          ld,
  input logic          gw_n,
  input logic          oe,
  input logic          rvalid,
  input logic          accept,
  input logic          awake,
  input logic          wr_fire,
  input logic [3:0]    wr_mask_q,
  input logic [AW-1:0] eff_addr
);
  AST_OE_GATES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rvalid); // R9
  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(ce1 && ce2 && !ce3_n)); // R5
  AST_NO_WRITE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !$past(sleep)); // R6
  AST_WAKE_NOT_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !awake); // R6
  AST_SLEEP_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ##2 !rvalid); // R6
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && $past(!gw_n)) |-> (wr_mask_q == 4'hF)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(accept, 2)); // R7
  AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ld) |=> $stable(eff_addr[AW-1:2])); // R4
endmodule

bind pburst_sram pbs_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1(ce1), .ce2(ce2), .ce3_n(ce3_n),
  .ld(ld), .gw_n(gw_n), .oe(oe), .rvalid(rvalid), .accept(accept),
  .awake(awake), .wr_fire(wr_fire), .wr_mask_q(wr_mask_q), .eff_addr(eff_addr)
);

// File: tb/tb_pburst_sram.sv
module tb_pburst_sram;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0, ce1 = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          ld = 1'b0, adv = 1'b0, linear = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [31:0]   wdata = '0;
  logic          oe = 1'b1;
  logic [31:0]   rdata;
  logic          rvalid;

  int n_total = 0, n_pass = 0;
  logic [31:0] model [1<<AW];

  always #5 clk = ~clk;

  pburst_sram #(.ADDR_W(AW), .WAKE_CYCLES(3)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1(ce1), .ce2(ce2), .ce3_n(ce3_n),
    .ld(ld), .adv(adv), .linear(linear), .addr(addr), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .oe(oe), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  task automatic idle();
    ce1 = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; ld = 1'b0; adv = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Issue one write at a loaded address and update the bench model.
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic g, input logic be, input logic [3:0] b);
    logic [3:0] m;
    ce1 = 1'b1; ld = 1'b1; addr = a; wdata = d; gw_n = g; bwe_n = be; bw_n = b;
    tick();
    idle();
    m = !g ? 4'hF : (!be ? ~b : 4'h0);
    for (int i = 0; i < 4; i++)
      if (m[i]) model[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    ce1 = 1'b1; ld = 1'b1; addr = a;
    tick();
    idle();
    tick();
    check({req, " valid"}, {31'd0, rvalid}, 32'd1);
    check({req, " data"}, rdata, model[a]);
  endtask

  task automatic t_reset();
    check("R10 rvalid", {31'd0, rvalid}, 32'd0);
    check("R10 rdata", rdata, 32'd0);
  endtask

  task automatic t_bytes();
    do_write(6'h08, 32'hA5A5_A5A5, 1'b0, 1'b1, 4'hF);
    do_read(6'h08, "R2 gw");                         // also R8 read after write
    do_write(6'h08, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
    check("R1 lanes 0,2 model", model[6'h08], 32'hA522_A544);
    do_read(6'h08, "R1 lanes");
    do_write(6'h08, 32'h0000_0000, 1'b1, 1'b1, 4'h0);   // bwe_n high: read
    do_read(6'h08, "R3 bwe high");
    do_write(6'h08, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF);   // no lane strobes: read
    do_read(6'h08, "R3 no lanes");
    do_write(6'h08, 32'hDEAD_BEEF, 1'b0, 1'b1, 4'hF);
    check("R2 model", model[6'h08], 32'hDEAD_BEEF);
    do_read(6'h08, "R2 overrides");
    do_write(6'h09, 32'h0BAD_F00D, 1'b0, 1'b1, 4'hF);
    do_read(6'h09, "R8 raw");
  endtask

  task automatic t_select();
    do_write(6'h05, 32'h1111_2222, 1'b0, 1'b1, 4'hF);
    for (int k = 0; k < 3; k++) begin
      ce1 = (k != 0); ce2 = (k != 1); ce3_n = (k == 2);
      ld = 1'b1; addr = 6'h05; wdata = 32'h9999_9999; gw_n = 1'b0;
      tick();
      idle();
      do_read(6'h05, "R5 deselected write");
    end
    ce1 = 1'b1; ce2 = 1'b0; ld = 1'b1; addr = 6'h05;
    tick(); idle(); tick();
    check("R5 deselected read", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_sleep();
    sleep = 1'b1;
    ce1 = 1'b1; ld = 1'b1; addr = 6'h05; wdata = 32'h7777_7777; gw_n = 1'b0;
    tick(); tick();
    sleep = 1'b0;
    for (int k = 0; k < 3; k++) tick();   // three ignored edges after sleep falls
    idle();
    do_read(6'h05, "R6 kept");
    sleep = 1'b1; ce1 = 1'b1; ld = 1'b1; addr = 6'h05;
    tick(); tick();
    check("R6 read asleep", {31'd0, rvalid}, 32'd0);
    sleep = 1'b0;
    tick(); tick(); tick();             // three ignored edges
    check("R6 read in wake window", {31'd0, rvalid}, 32'd0);
    tick();                             // fourth edge takes the read
    idle();
    tick();
    check("R6 fourth edge taken", {31'd0, rvalid}, 32'd1);
    check("R6 fourth edge data", rdata, model[6'h05]);
  endtask

  task automatic t_burst(input logic [AW-1:0] b, input logic lin, input string req);
    logic [1:0]    off;
    logic [AW-1:0] prev;
    logic [4:0]    advs;
    off = 2'd0; prev = '0; advs = 5'b11010;   // steps 1..4: adv,hold,adv,adv
    for (int i = 0; i < 4; i++) do_write({b[AW-1:2], 2'(i)}, 32'hC0DE_0000 + 32'(b) * 16 + 32'(i),
                                         1'b0, 1'b1, 4'hF);
    linear = lin;
    for (int i = 0; i < 5; i++) begin
      ce1 = 1'b1; ld = (i == 0); adv = (i != 0) && advs[i]; addr = b;
      if (adv) off = off + 2'd1;
      tick();
      if (i > 0) begin
        check({req, " valid"}, {31'd0, rvalid}, 32'd1);   // R7 one word per cycle
        check({req, " data"}, rdata, model[prev]);
      end
      prev = {b[AW-1:2], lin ? (b[1:0] + off) : (b[1:0] ^ off)};
    end
    idle();
    tick();
    check({req, " last"}, rdata, model[prev]);
    linear = 1'b1;
  endtask

  task automatic t_oe();
    oe = 1'b0;
    ce1 = 1'b1; ld = 1'b1; addr = 6'h09;
    tick(); idle(); tick();
    check("R9 oe low valid", {31'd0, rvalid}, 32'd0);
    check("R9 oe low data", rdata, 32'd0);
    oe = 1'b1;
    #1;
    check("R9 oe async valid", {31'd0, rvalid}, 32'd1);
    check("R9 oe async data", rdata, model[6'h09]);
    check("R7 latency word", rdata, 32'h0BAD_F00D);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_bytes();
    t_select();
    t_sleep();
    t_burst(6'h3D, 1'b1, "R4 linear top");
    t_burst(6'h12, 1'b0, "R4 interleaved");
    t_oe();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule